// File: doc/BRIEF.md
# Paged CSR access sequencer

This block turns a single register request into the bus steps needed to reach a 4 KB control/status register space where only the lower part is mapped directly. A requester presents a flat 12-bit offset, a byte count of 1, 2 or 4, a read/write flag and write data. Offsets below 0xC00 are reached directly. Anything from 0xC00 upward is reached through a 1 KB window whose page is chosen by a 6-bit page-select field held in a control register.

Each accepted request that passes the size and alignment checks always becomes three bus transfers in a fixed order. First the control register is read. Then it is written back with the page-select field replaced: zero for a direct offset, or the offset's upper bits for a paged one. Finally the data transfer goes to the translated address. A request that fails the checks gets an error code at once and never reaches the bus. The response, with read data zero-extended from the addressed byte lane, stays valid until the requester takes it.

Top module: `paged_csr_seq`

## Requirements
- R1: For an offset below 0xC00, the page-select field (control register bits [18:13]) is written to 0 and the data transfer uses the offset unchanged as its bus address.
- R2: For an offset of 0xC00 or above, the page-select field is written with (offset >> 10) & 0x3F and the data transfer address is (offset & 0x3FF) | 0xC00.
- R3: The control register write keeps every bit outside [18:13] at the value just read from it.
- R4: A request that passes the checks makes exactly three bus transfers in this order: a read of the control register, a write of the control register, then the data transfer; the response follows the third.
- R5: A size other than 1, 2 or 4 gets status 2'b01 and read data 0, and makes no bus transfer.
- R6: A legal size whose offset is not a multiple of the size gets status 2'b10 and read data 0, and makes no bus transfer, so a rejected write leaves the target unchanged.
- R7: A successful access returns status 2'b00; a 1- or 2-byte read returns the byte or halfword that starts at byte lane offset[1:0] of the bus word, zero-extended to 32 bits, and a write returns data 0.
- R8: The data transfer drives byte strobes ((1 << size) - 1) << offset[1:0] with write data shifted into lane offset[1:0]; control register transfers drive all four strobes.
- R9: req_ready is high only while the block is idle with no response pending, and a response holds its valid, data and status unchanged until rsp_ready is seen.
- R10: A bus request stays asserted with address, direction and write data unchanged until bus_ack is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block can take a request |
| req_offset_i | input | 12 | Flat register offset |
| req_size_i | input | 3 | Access size in bytes |
| req_write_i | input | 1 | 1 for write, 0 for read |
| req_wdata_i | input | 32 | Write data, right-justified |
| rsp_valid_o | output | 1 | Response present |
| rsp_ready_i | input | 1 | Requester takes the response |
| rsp_rdata_o | output | 32 | Read data, zero-extended |
| rsp_status_o | output | 2 | 00 ok, 01 bad size, 10 misaligned |
| bus_req_o | output | 1 | Bus transfer request |
| bus_we_o | output | 1 | Bus transfer is a write |
| bus_addr_o | output | 12 | Bus byte address |
| bus_wdata_o | output | 32 | Bus write data |
| bus_strb_o | output | 4 | Bus byte strobes |
| bus_ack_i | input | 1 | Bus transfer complete, read data valid |
| bus_rdata_i | input | 32 | Bus read data |

## Verification
The bench goes after the offsets on either side of the 0xC00 boundary and the last byte of the space, where a design that compared the wrong bound or masked the wrong bits would send a paged access to the direct region or leave a stale page selected for the next direct one. It writes sub-word values into shared words and reads them back at every width, which exposes a wrong strobe, a wrong lane shift or missing zero extension. It also sends sizes 0, 3 and 5 and misaligned offsets, then reads the target back; a design that checked late would touch the control register or write the data. A slave model with varying latency and a requester that stalls on responses expose any design that drops a request or a response before its handshake.

// File: rtl/paged_csr_pkg.sv
package paged_csr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_CTRL,
    ST_WR_CTRL,
    ST_DATA,
    ST_RESP
  } seq_state_t;

  localparam logic [1:0] RSP_OK       = 2'b00;
  localparam logic [1:0] RSP_BAD_SIZE = 2'b01;
  localparam logic [1:0] RSP_MISALIGN = 2'b10;

endpackage

// File: rtl/csr_addr_xlate.sv
module csr_addr_xlate #(
  parameter int OFF_W  = 12,
  parameter int WIN_W  = 10,
  parameter int PAGE_W = 6,
  parameter logic [OFF_W-1:0] BOUNDARY = 12'hC00
) (
  input  logic [OFF_W-1:0]  offset_i,
  input  logic [2:0]        size_i,
  output logic              size_ok_o,
  output logic              align_ok_o,
  output logic              paged_o,
  output logic [PAGE_W-1:0] page_o,
  output logic [OFF_W-1:0]  bus_off_o
);

  localparam logic [OFF_W-1:0] LO_MASK = OFF_W'((1 << WIN_W) - 1);
  localparam int EXT_W = OFF_W + PAGE_W + WIN_W;

  logic [EXT_W-1:0] off_ext;
  logic [2:0]       size_m1;

  always_comb begin
    off_ext    = EXT_W'(offset_i);
    size_m1    = size_i - 3'd1;
    size_ok_o  = (size_i == 3'd1) || (size_i == 3'd2) || (size_i == 3'd4);
    align_ok_o = ((offset_i[2:0] & size_m1) == 3'd0);
    paged_o    = (offset_i >= BOUNDARY);
    page_o     = off_ext[WIN_W +: PAGE_W];
    bus_off_o  = paged_o ? ((offset_i & LO_MASK) | BOUNDARY) : offset_i;
  end

endmodule

// File: rtl/csr_pgsel_merge.sv
module csr_pgsel_merge #(
  parameter int DATA_W    = 32,
  parameter int PAGE_W    = 6,
  parameter int FIELD_LSB = 13
) (
  input  logic [DATA_W-1:0] cur_i,
  input  logic [PAGE_W-1:0] page_i,
  output logic [DATA_W-1:0] merged_o
);

  localparam logic [DATA_W-1:0] FIELD_MASK = DATA_W'((1 << PAGE_W) - 1) << FIELD_LSB;

  always_comb begin
    merged_o = (cur_i & ~FIELD_MASK) | (DATA_W'(page_i) << FIELD_LSB);
  end

endmodule

// File: rtl/csr_lane_unit.sv
module csr_lane_unit #(
  parameter int DATA_W = 32,
  parameter int LANE_W = $clog2(DATA_W / 8)
) (
  input  logic [LANE_W-1:0]     lane_i,
  input  logic [2:0]            size_i,
  input  logic [DATA_W-1:0]     wdata_i,
  input  logic [DATA_W-1:0]     rdata_i,
  output logic [DATA_W/8-1:0]   strb_o,
  output logic [DATA_W-1:0]     wlane_o,
  output logic [DATA_W-1:0]     rext_o
);

  localparam int STRB_W = DATA_W / 8;

  logic [STRB_W-1:0] base;
  logic [DATA_W-1:0] rshift;
  logic [LANE_W+2:0] bit_sh;

  always_comb begin
    bit_sh = {lane_i, 3'b000};
    case (size_i)
      3'd1:    base = STRB_W'(1);
      3'd2:    base = STRB_W'(3);
      default: base = '1;
    endcase
    strb_o  = base << lane_i;
    wlane_o = wdata_i << bit_sh;
    rshift  = rdata_i >> bit_sh;
    case (size_i)
      3'd1:    rext_o = DATA_W'(rshift[7:0]);
      3'd2:    rext_o = DATA_W'(rshift[15:0]);
      default: rext_o = rshift;
    endcase
  end

endmodule

// File: rtl/paged_csr_seq.sv
module paged_csr_seq
  import paged_csr_pkg::*;
#(
  parameter int OFF_W     = 12,
  parameter int DATA_W    = 32,
  parameter int WIN_W     = 10,
  parameter int PAGE_W    = 6,
  parameter int PAGE_LSB  = 13,
  parameter logic [OFF_W-1:0] BOUNDARY  = 12'hC00,
  parameter logic [OFF_W-1:0] CTRL_ADDR = 12'h008
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic [OFF_W-1:0]    req_offset_i,
  input  logic [2:0]          req_size_i,
  input  logic                req_write_i,
  input  logic [DATA_W-1:0]   req_wdata_i,
  output logic                rsp_valid_o,
  input  logic                rsp_ready_i,
  output logic [DATA_W-1:0]   rsp_rdata_o,
  output logic [1:0]          rsp_status_o,
  output logic                bus_req_o,
  output logic                bus_we_o,
  output logic [OFF_W-1:0]    bus_addr_o,
  output logic [DATA_W-1:0]   bus_wdata_o,
  output logic [DATA_W/8-1:0] bus_strb_o,
  input  logic                bus_ack_i,
  input  logic [DATA_W-1:0]   bus_rdata_i
);

  localparam int STRB_W = DATA_W / 8;
  localparam int LANE_W = $clog2(STRB_W);

  seq_state_t state;

  logic [OFF_W-1:0]  off_q;
  logic [2:0]        size_q;
  logic              we_q;
  logic [DATA_W-1:0] wdata_q;
  logic [PAGE_W-1:0] page_q;
  logic [OFF_W-1:0]  daddr_q;
  logic              ready_q;

  logic              x_size_ok;
  logic              x_align_ok;
  logic              x_paged;
  logic [PAGE_W-1:0] x_page;
  logic [OFF_W-1:0]  x_bus_off;
  logic [DATA_W-1:0] ctrl_merged;
  logic [STRB_W-1:0] lane_strb;
  logic [DATA_W-1:0] lane_wdata;
  logic [DATA_W-1:0] lane_rext;

  csr_addr_xlate #(
    .OFF_W   (OFF_W),
    .WIN_W   (WIN_W),
    .PAGE_W  (PAGE_W),
    .BOUNDARY(BOUNDARY)
  ) u_xlate (
    .offset_i  (req_offset_i),
    .size_i    (req_size_i),
    .size_ok_o (x_size_ok),
    .align_ok_o(x_align_ok),
    .paged_o   (x_paged),
    .page_o    (x_page),
    .bus_off_o (x_bus_off)
  );

  csr_pgsel_merge #(
    .DATA_W   (DATA_W),
    .PAGE_W   (PAGE_W),
    .FIELD_LSB(PAGE_LSB)
  ) u_merge (
    .cur_i   (bus_rdata_i),
    .page_i  (page_q),
    .merged_o(ctrl_merged)
  );

  csr_lane_unit #(
    .DATA_W(DATA_W),
    .LANE_W(LANE_W)
  ) u_lane (
    .lane_i (off_q[LANE_W-1:0]),
    .size_i (size_q),
    .wdata_i(wdata_q),
    .rdata_i(bus_rdata_i),
    .strb_o (lane_strb),
    .wlane_o(lane_wdata),
    .rext_o (lane_rext)
  );

  assign req_ready_o = ready_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state        <= ST_IDLE;
      ready_q      <= 1'b1;
      off_q        <= '0;
      size_q       <= '0;
      we_q         <= 1'b0;
      wdata_q      <= '0;
      page_q       <= '0;
      daddr_q      <= '0;
      bus_req_o    <= 1'b0;
      bus_we_o     <= 1'b0;
      bus_addr_o   <= '0;
      bus_wdata_o  <= '0;
      bus_strb_o   <= '0;
      rsp_valid_o  <= 1'b0;
      rsp_rdata_o  <= '0;
      rsp_status_o <= RSP_OK;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req_valid_i && ready_q) begin
            ready_q <= 1'b0;
            off_q   <= req_offset_i;
            size_q  <= req_size_i;
            we_q    <= req_write_i;
            wdata_q <= req_wdata_i;
            page_q  <= x_paged ? x_page : '0;
            daddr_q <= x_bus_off;
            if (!x_size_ok || !x_align_ok) begin
              // Rejected before any bus step: respond straight away.
              rsp_valid_o  <= 1'b1;
              rsp_rdata_o  <= '0;
              rsp_status_o <= !x_size_ok ? RSP_BAD_SIZE : RSP_MISALIGN;
              state        <= ST_RESP;
            end else begin
              bus_req_o   <= 1'b1;
              bus_we_o    <= 1'b0;
              bus_addr_o  <= CTRL_ADDR;
              bus_wdata_o <= '0;
              bus_strb_o  <= '1;
              state       <= ST_RD_CTRL;
            end
          end
        end
        ST_RD_CTRL: begin
          if (bus_ack_i) begin
            bus_we_o    <= 1'b1;
            bus_addr_o  <= CTRL_ADDR;
            bus_wdata_o <= ctrl_merged;
            bus_strb_o  <= '1;
            state       <= ST_WR_CTRL;
          end
        end
        ST_WR_CTRL: begin
          if (bus_ack_i) begin
            bus_we_o    <= we_q;
            bus_addr_o  <= daddr_q;
            bus_wdata_o <= we_q ? lane_wdata : '0;
            bus_strb_o  <= lane_strb;
            state       <= ST_DATA;
          end
        end
        ST_DATA: begin
          if (bus_ack_i) begin
            bus_req_o    <= 1'b0;
            bus_we_o     <= 1'b0;
            bus_strb_o   <= '0;
            rsp_valid_o  <= 1'b1;
            rsp_rdata_o  <= we_q ? '0 : lane_rext;
            rsp_status_o <= RSP_OK;
            state        <= ST_RESP;
          end
        end
        ST_RESP: begin
          if (rsp_ready_i) begin
            rsp_valid_o <= 1'b0;
            ready_q     <= 1'b1;
            state       <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/paged_csr_seq_chk.sv
module paged_csr_seq_chk #(
  parameter int OFF_W  = 12,
  parameter int DATA_W = 32
) (
  input logic                clk_i,
  input logic                rst_i,
  input logic                req_valid_i,
  input logic                req_ready_o,
  input logic [OFF_W-1:0]    req_offset_i,
  input logic [2:0]          req_size_i,
  input logic                req_write_i,
  input logic [DATA_W-1:0]   req_wdata_i,
  input logic                rsp_valid_o,
  input logic                rsp_ready_i,
  input logic [DATA_W-1:0]   rsp_rdata_o,
  input logic [1:0]          rsp_status_o,
  input logic                bus_req_o,
  input logic                bus_we_o,
  input logic [OFF_W-1:0]    bus_addr_o,
  input logic [DATA_W-1:0]   bus_wdata_o,
  input logic [DATA_W/8-1:0] bus_strb_o,
  input logic                bus_ack_i,
  input logic [DATA_W-1:0]   bus_rdata_i
);

  a_r10_bus_hold: assert property (@(posedge clk_i) disable iff (rst_i)
    bus_req_o && !bus_ack_i |=> bus_req_o && $stable(bus_addr_o) && $stable(bus_we_o)
                                && $stable(bus_wdata_o) && $stable(bus_strb_o));

  a_r9_rsp_hold: assert property (@(posedge clk_i) disable iff (rst_i)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_rdata_o) && $stable(rsp_status_o));

  a_r9_ready_idle: assert property (@(posedge clk_i) disable iff (rst_i)
    req_ready_o |-> !rsp_valid_o && !bus_req_o);

  a_r4_rsp_after_bus: assert property (@(posedge clk_i) disable iff (rst_i)
    rsp_valid_o |-> !bus_req_o);

  a_r5_err_zero: assert property (@(posedge clk_i) disable iff (rst_i)
    rsp_valid_o && (rsp_status_o != 2'b00) |-> rsp_rdata_o == '0);

  a_r7_status_code: assert property (@(posedge clk_i) disable iff (rst_i)
    rsp_valid_o |-> rsp_status_o != 2'b11);

  a_r8_strb_active: assert property (@(posedge clk_i) disable iff (rst_i)
    bus_req_o |-> bus_strb_o != '0);

  a_r6_reject_quiet: assert property (@(posedge clk_i) disable iff (rst_i)
    req_valid_i && req_ready_o && (req_size_i == 3'd4) && (req_offset_i[1:0] != 2'b00)
    |=> !bus_req_o && rsp_valid_o && (rsp_status_o == 2'b10));

endmodule

bind paged_csr_seq paged_csr_seq_chk #(.OFF_W(OFF_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/paged_csr_seq_tb.sv
module paged_csr_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] CTRL = 12'h008;
  localparam logic [31:0] CTRL_INIT = 32'hA5A5_A5A5;
  localparam logic [31:0] FMASK = 32'h0007_E000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [11:0] req_offset = '0;
  logic [2:0]  req_size = '0;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;
  logic [1:0]  rsp_status;
  logic        bus_req;
  logic        bus_we;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [3:0]  bus_strb;
  logic        bus_ack = 1'b0;
  logic [31:0] bus_rdata = '0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  paged_csr_seq u_dut (
    .clk_i(clk), .rst_i(rst),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_offset_i(req_offset), .req_size_i(req_size),
    .req_write_i(req_write), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready),
    .rsp_rdata_o(rsp_rdata), .rsp_status_o(rsp_status),
    .bus_req_o(bus_req), .bus_we_o(bus_we), .bus_addr_o(bus_addr),
    .bus_wdata_o(bus_wdata), .bus_strb_o(bus_strb),
    .bus_ack_i(bus_ack), .bus_rdata_i(bus_rdata)
  );

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Slave model: direct region keyed by address, paged region keyed by page too.
  logic [31:0] smem [int];
  int lat = 0;
  int wcnt = 0;

  function automatic int skey(input logic [11:0] a);
    logic [31:0] c;
    int base;
    c = smem.exists(int'(CTRL)) ? smem[int'(CTRL)] : 32'h0;
    base = int'({a[11:2], 2'b00});
    if (a >= 12'hC00) return int'(c[18:13]) * 4096 + base;
    return base;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      bus_ack <= 1'b0;
      wcnt = 0;
    end else begin
      bus_ack <= 1'b0;
      if (bus_req && !bus_ack) begin
        if (wcnt < lat) begin
          wcnt++;
        end else begin
          int k;
          logic [31:0] w;
          wcnt = 0;
          lat = (lat + 1) % 3;
          k = skey(bus_addr);
          w = smem.exists(k) ? smem[k] : 32'h0;
          bus_ack <= 1'b1;
          if (bus_we) begin
            for (int b = 0; b < 4; b++)
              if (bus_strb[b]) w[8*b +: 8] = bus_wdata[8*b +: 8];
            smem[k] = w;
          end else begin
            bus_rdata <= w;
          end
        end
      end
    end
  end

  // Bus monitor
  int nb = 0;
  logic [11:0] t_addr [3];
  logic        t_we [3];
  logic [3:0]  t_strb [3];
  logic        pend = 1'b0;
  logic [11:0] pend_addr;
  logic [31:0] pend_wdata;

  always @(negedge clk) begin
    if (!rst) begin
      if (pend && bus_req)
        chk(bus_addr == pend_addr && bus_wdata == pend_wdata, "R10", "held bus request",
            {20'h0, bus_addr}, {20'h0, pend_addr});
      pend = bus_req && !bus_ack;
      pend_addr = bus_addr;
      pend_wdata = bus_wdata;
      if (bus_req && bus_ack) begin
        if (nb < 3) begin
          t_addr[nb] = bus_addr;
          t_we[nb] = bus_we;
          t_strb[nb] = bus_strb;
        end
        nb++;
      end
    end
  end

  // Scoreboard
  typedef struct {
    logic [1:0]  st;
    logic [31:0] rd;
    int          nbus;
    logic [11:0] daddr;
    logic [3:0]  dstrb;
    logic        dwe;
    logic [5:0]  pg;
    string       req;
  } exp_t;

  exp_t exp_q[$];
  logic [7:0] ref_mem [0:4095];
  int rcyc = 0;
  bit held = 1'b0;
  logic [31:0] held_rd;
  logic [1:0] held_st;

  always @(negedge clk) begin
    if (!rst) begin
      rcyc++;
      rsp_ready = (rcyc % 4) != 1;
      if (held && rsp_valid)
        chk(rsp_rdata == held_rd && rsp_status == held_st, "R9", "held response",
            rsp_rdata, held_rd);
      held = rsp_valid && !rsp_ready;
      held_rd = rsp_rdata;
      held_st = rsp_status;
      if (rsp_valid && rsp_ready) begin
        exp_t e;
        logic [31:0] c;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R4", "unexpected response", 32'h1, 32'h0);
        end else begin
          e = exp_q.pop_front();
          chk(rsp_status == e.st, e.req, "status", {30'h0, rsp_status}, {30'h0, e.st});
          chk(rsp_rdata == e.rd, e.req, "read data", rsp_rdata, e.rd);
          chk(nb == e.nbus, e.req, "bus transfer count", nb, e.nbus);
          chk(req_ready == 1'b0, "R9", "ready while responding", {31'h0, req_ready}, 32'h0);
          if (e.nbus == 3 && nb == 3) begin
            chk(t_addr[0] == CTRL && !t_we[0] && t_addr[1] == CTRL && t_we[1], "R4",
                "control read then write", {19'h0, t_we[1], t_addr[1]}, {19'h1, CTRL});
            chk(t_strb[1] == 4'hF, "R8", "control strobes", {28'h0, t_strb[1]}, 32'hF);
            chk(t_addr[2] == e.daddr, e.req, "data address", {20'h0, t_addr[2]}, {20'h0, e.daddr});
            chk(t_we[2] == e.dwe && t_strb[2] == e.dstrb, "R8", "data strobes",
                {27'h0, t_we[2], t_strb[2]}, {27'h0, e.dwe, e.dstrb});
            c = smem[int'(CTRL)];
            chk(c[18:13] == e.pg, e.req, "page field", {26'h0, c[18:13]}, {26'h0, e.pg});
            chk((c & ~FMASK) == (CTRL_INIT & ~FMASK), "R3", "control bits kept",
                c & ~FMASK, CTRL_INIT & ~FMASK);
          end
        end
        nb = 0;
      end
    end
  end

  task automatic do_req(input logic [11:0] off, input logic [2:0] sz, input logic we,
                        input logic [31:0] wd, input string req);
    exp_t e;
    bit size_ok;
    bit align_ok;
    size_ok = (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
    align_ok = ((off[2:0] & (sz - 3'd1)) == 3'd0);
    e.req = req;
    e.rd = 32'h0;
    e.dwe = we;
    e.daddr = (off >= 12'hC00) ? ((off & 12'h3FF) | 12'hC00) : off;
    e.pg = (off >= 12'hC00) ? 6'((off >> 10) & 12'h3F) : 6'h0;
    e.dstrb = 4'(((1 << sz) - 1) << off[1:0]);
    if (!size_ok) begin
      e.st = 2'b01; e.nbus = 0;
    end else if (!align_ok) begin
      e.st = 2'b10; e.nbus = 0;
    end else begin
      e.st = 2'b00; e.nbus = 3;
      for (int i = 0; i < int'(sz); i++) begin
        if (we) ref_mem[int'(off) + i] = wd[8*i +: 8];
        else e.rd[8*i +: 8] = ref_mem[int'(off) + i];
      end
    end
    exp_q.push_back(e);
    @(negedge clk);
    req_valid = 1'b1;
    req_offset = off;
    req_size = sz;
    req_write = we;
    req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) ref_mem[i] = 8'h00;
    smem[int'(CTRL)] = CTRL_INIT;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(req_ready == 1'b1, "R9", "reset ready", {31'h0, req_ready}, 32'h1);
    chk(rsp_valid == 1'b0, "R9", "reset response", {31'h0, rsp_valid}, 32'h0);
    chk(bus_req == 1'b0, "R10", "reset bus request", {31'h0, bus_req}, 32'h0);

    do_req(12'h010, 3'd4, 1'b1, 32'h1122_3344, "R1");
    do_req(12'h010, 3'd4, 1'b0, 32'h0, "R1");
    do_req(12'hC40, 3'd4, 1'b1, 32'hCAFE_F00D, "R2");
    do_req(12'hC40, 3'd4, 1'b0, 32'h0, "R2");
    do_req(12'h040, 3'd4, 1'b0, 32'h0, "R2");
    do_req(12'h021, 3'd1, 1'b1, 32'h0000_00AB, "R8");
    do_req(12'h022, 3'd2, 1'b1, 32'h0000_5A6B, "R8");
    do_req(12'h020, 3'd4, 1'b0, 32'h0, "R7");
    do_req(12'h021, 3'd1, 1'b0, 32'h0, "R7");
    do_req(12'h022, 3'd2, 1'b0, 32'h0, "R7");
    do_req(12'hFFF, 3'd1, 1'b1, 32'h0000_0077, "R2");
    do_req(12'hFFF, 3'd1, 1'b0, 32'h0, "R7");
    do_req(12'hFFC, 3'd4, 1'b0, 32'h0, "R2");
    do_req(12'hBFC, 3'd4, 1'b1, 32'h0BFC_0BFC, "R1");
    do_req(12'hC00, 3'd4, 1'b1, 32'h0C00_0C00, "R2");
    do_req(12'hBFC, 3'd4, 1'b0, 32'h0, "R1");
    do_req(12'hC00, 3'd4, 1'b0, 32'h0, "R2");
    do_req(12'h030, 3'd3, 1'b1, 32'hDEAD_BEEF, "R5");
    do_req(12'h030, 3'd0, 1'b0, 32'h0, "R5");
    do_req(12'h030, 3'd5, 1'b0, 32'h0, "R5");
    do_req(12'h012, 3'd4, 1'b0, 32'h0, "R6");
    do_req(12'hC81, 3'd2, 1'b1, 32'h0000_BEEF, "R6");
    do_req(12'h031, 3'd4, 1'b1, 32'h1234_5678, "R6");
    do_req(12'h030, 3'd4, 1'b0, 32'h0, "R6");
    do_req(12'hC80, 3'd4, 1'b0, 32'h0, "R6");
    do_req(12'hC82, 3'd2, 1'b1, 32'h0000_9876, "R8");
    do_req(12'hC82, 3'd2, 1'b0, 32'h0, "R7");
    do_req(12'h020, 3'd4, 1'b0, 32'h0, "R1");

    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      chk(1'b0, "R4", "watchdog expired", 32'h0, 32'h1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule